// File: doc/BRIEF.md
# Staged Polyphase Coefficient Loader

This block collects the coefficient rows of a polyphase anti-alias filter from a simple write bus and stores them in four independent phase tables: horizontal luma, horizontal chroma, vertical luma and vertical chroma. Coefficient words are never written directly into a table. Software first writes the staging words of a table. It then writes that table's trigger address. The trigger write commits the whole row, made of the staged words plus the trigger word itself, into the phase slot named by the table's own write pointer. The pointer then steps to the next of the 16 phases.

A horizontal table holds five staging words per row and a vertical table holds two. Everything else about the two kinds of table is the same. The filter datapath fetches a full phase row through a registered read port. It also receives one bypass flag for the horizontal direction and one for the vertical direction. A sticky per-table flag reports a trigger that arrived before all staging words of the row had been written.

Top module: `coef_loader_top`

## Requirements
- R1: The write address is 6 bits. Bits [5:3] select the target: 0 is horizontal luma, 1 is horizontal chroma, 2 is vertical luma, 3 is vertical chroma and 4 is the control word. Bits [2:0] select a slot: slots 0 to N-1 are staging words (N is 5 for horizontal tables and 2 for vertical tables), slot 6 is pointer clear and slot 7 is the trigger. Writes to any other slot or target change nothing.
- R2: A staging write changes neither the stored rows nor the phase pointer of any table.
- R3: A trigger write stores one row at the table's current pointer. Staging word i goes to bits [32i+31:32i], the trigger data goes to word N, and the words above N read as zero.
- R4: Each table's 4-bit phase pointer increments by one on every trigger write to that table and wraps from 15 to 0.
- R5: Reset, or a pointer-clear write to a table, sets that table's pointer to 0, clears its sticky error flag and forgets which staging words were written.
- R6: A write to one table never changes the pointer, error flag, staging words or rows of any other table.
- R7: A table's sticky error flag is set by a trigger that arrives before each of its staging slots has been written since the last trigger, clear or reset. The flag stays set until a clear or a reset.
- R8: Staging words keep their values after a trigger, so a following trigger commits them again.
- R9: A write to the control word sets the horizontal bypass output from data bit 16 and the vertical bypass output from data bit 17. Both outputs are 0 after reset.
- R10: The row of table rd_table at phase rd_phase appears on rd_row one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write address: target in [5:3], slot in [2:0] |
| wr_data | input | 32 | Write data |
| rd_table | input | 2 | Table to read (0 to 3) |
| rd_phase | input | 4 | Phase row to read |
| rd_row | output | 192 | Registered phase row, word 0 in the low bits |
| phase_ptr | output | 16 | Write pointers, table t at bits [4t+3:4t] |
| seq_err | output | 4 | Sticky incomplete-row flags, one per table |
| h_bypass | output | 1 | Horizontal filter bypass |
| v_bypass | output | 1 | Vertical filter bypass |

## Verification
The bench builds the block with its defaults: 32-bit words, 16 phases, five horizontal and two vertical staging words. With these values a complete table program, and the wrap of the pointer back to phase 0, takes only a few dozen writes. The random phase can therefore cross the wrap, fire incomplete triggers, clear tables and write to unused slots many times. Every row written is read back in both the five-word and the two-word layout.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int NTBL = 4;
  localparam int AW = 6;
  localparam logic [2:0] SLOT_TRIG = 3'd7;
  localparam logic [2:0] SLOT_CLR = 3'd6;
  localparam logic [2:0] TGT_CTRL = 3'd4;
  localparam int HBYP_BIT = 16;
  localparam int VBYP_BIT = 17;
endpackage

// File: rtl/coef_ctrl.sv
module coef_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          h_byp,
  output logic          v_byp
);
  import coef_pkg::*;
  logic h_d, v_d;

  always_comb begin
    h_d = h_byp;
    v_d = v_byp;
    if (we) begin
      h_d = wdata[HBYP_BIT];
      v_d = wdata[VBYP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_byp <= 1'b0;
      v_byp <= 1'b0;
    end else begin
      h_byp <= h_d;
      v_byp <= v_d;
    end
  end

  assert_byp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(h_byp) && $stable(v_byp)));
endmodule

// File: rtl/coef_table.sv
module coef_table #(
  parameter int NSTG   = 5,
  parameter int DW     = 32,
  parameter int PHASES = 16,
  localparam int PW    = $clog2(PHASES),
  localparam int ROWW  = (NSTG + 1) * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      slot,
  input  logic [DW-1:0]   wdata,
  input  logic [PW-1:0]   rd_phase,
  output logic [ROWW-1:0] rd_row,
  output logic [PW-1:0]   ptr,
  output logic            err
);
  import coef_pkg::*;

  logic [NSTG-1:0]      stg_we;
  logic [NSTG*DW-1:0]   stg_flat;
  logic [NSTG-1:0]      mask_q, mask_d;
  logic [PW-1:0]        ptr_d;
  logic                 err_d;
  logic                 trig, clr;
  logic [ROWW-1:0]      mem [PHASES];

  assign trig = we && (slot == SLOT_TRIG);
  assign clr  = we && (slot == SLOT_CLR);

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    localparam logic [2:0] SLOT_I = 3'(i);
    logic [DW-1:0] stg_q;
    assign stg_we[i] = we && (slot == SLOT_I);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stg_q <= '0;
      else if (stg_we[i]) stg_q <= wdata;
    end
    assign stg_flat[i*DW +: DW] = stg_q;
  end

  always_comb begin
    ptr_d  = ptr;
    err_d  = err;
    mask_d = mask_q | stg_we;
    if (clr) begin
      ptr_d  = '0;
      err_d  = 1'b0;
      mask_d = '0;
    end else if (trig) begin
      ptr_d  = ptr + 1'b1;
      err_d  = err | (mask_q != {NSTG{1'b1}});
      mask_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      err    <= 1'b0;
      mask_q <= '0;
    end else begin
      ptr    <= ptr_d;
      err    <= err_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (trig) mem[ptr] <= {wdata, stg_flat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_row <= '0;
    else        rd_row <= mem[rd_phase];
  end

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> ptr == PW'($past(ptr) + 1'b1));
  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !clr) |=> $stable(ptr));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0 && !err));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);
endmodule

// File: rtl/coef_loader_top.sv
module coef_loader_top #(
  parameter int DW     = 32,
  parameter int PHASES = 16,
  parameter int H_STG  = 5,
  parameter int V_STG  = 2,
  localparam int PW    = $clog2(PHASES),
  localparam int ROWW  = (H_STG + 1) * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [5:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [1:0]         rd_table,
  input  logic [PW-1:0]      rd_phase,
  output logic [ROWW-1:0]    rd_row,
  output logic [4*PW-1:0]    phase_ptr,
  output logic [3:0]         seq_err,
  output logic               h_bypass,
  output logic               v_bypass
);
  import coef_pkg::*;

  logic [2:0]      wr_tgt, wr_slot;
  logic [NTBL-1:0] tbl_we;
  logic            ctrl_we;
  logic [ROWW-1:0] rows [NTBL];
  logic [1:0]      rd_tbl_q;

  assign wr_tgt  = wr_addr[5:3];
  assign wr_slot = wr_addr[2:0];
  assign ctrl_we = wr_en && (wr_tgt == TGT_CTRL) && (wr_slot == 3'd0);

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    localparam int NS = (t < 2) ? H_STG : V_STG;
    localparam logic [2:0] TGT_T = 3'(t);
    logic [(NS+1)*DW-1:0] row;
    assign tbl_we[t] = wr_en && (wr_tgt == TGT_T);
    coef_table #(.NSTG(NS), .DW(DW), .PHASES(PHASES)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (tbl_we[t]),
      .slot     (wr_slot),
      .wdata    (wr_data),
      .rd_phase (rd_phase),
      .rd_row   (row),
      .ptr      (phase_ptr[t*PW +: PW]),
      .err      (seq_err[t])
    );
    assign rows[t] = ROWW'(row);
  end

  coef_ctrl #(.DW(DW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .wdata (wr_data),
    .h_byp (h_bypass),
    .v_byp (v_bypass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_tbl_q <= '0;
    else        rd_tbl_q <= rd_table;
  end

  assign rd_row = rows[rd_tbl_q];

  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tbl_we, ctrl_we}));
  assert_other_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_we[0] |=> $stable(phase_ptr[PW-1:0]));
endmodule

// File: tb/coef_loader_top_tb.sv
module coef_loader_top_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [5:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [1:0]   rd_table;
  logic [3:0]   rd_phase;
  logic [191:0] rd_row;
  logic [15:0]  phase_ptr;
  logic [3:0]   seq_err;
  logic         h_bypass, v_bypass;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [191:0] m_row [4][16];
  bit           m_val [4][16];
  int           m_ptr [4];
  bit           m_err [4];
  logic [31:0]  m_stg [4][6];
  int           m_mask[4];
  bit           m_h, m_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_loader_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_table(rd_table), .rd_phase(rd_phase), .rd_row(rd_row), .phase_ptr(phase_ptr),
    .seq_err(seq_err), .h_bypass(h_bypass), .v_bypass(v_bypass)
  );

  function automatic int nstg(int t);
    return (t < 2) ? 5 : 2;
  endfunction

  task automatic chk(string req, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int t = 0; t < 4; t++) begin
      m_ptr[t] = 0; m_err[t] = 0; m_mask[t] = 0;
      for (int i = 0; i < 6; i++) m_stg[t][i] = '0;
      for (int p = 0; p < 16; p++) m_val[t][p] = 0;
    end
    m_h = 0; m_v = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    int t, s, n;
    logic [191:0] r;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    t = int'(a[5:3]); s = int'(a[2:0]);
    if (t == 4 && s == 0) begin
      m_h = d[16]; m_v = d[17];
    end else if (t < 4) begin
      n = nstg(t);
      if (s < n) begin
        m_stg[t][s] = d;
        m_mask[t] |= (1 << s);
      end else if (s == 6) begin
        m_ptr[t] = 0; m_err[t] = 0; m_mask[t] = 0;
      end else if (s == 7) begin
        r = '0;
        for (int i = 0; i < n; i++) r[i*32 +: 32] = m_stg[t][i];
        r[n*32 +: 32] = d;
        m_row[t][m_ptr[t]] = r;
        m_val[t][m_ptr[t]] = 1;
        if (m_mask[t] != (1 << n) - 1) m_err[t] = 1;
        m_mask[t] = 0;
        m_ptr[t] = (m_ptr[t] + 1) % 16;
      end
    end
  endtask

  task automatic rd(int t, int p, output logic [191:0] r);
    @(negedge clk);
    rd_table = 2'(t); rd_phase = 4'(p);
    @(negedge clk);
    r = rd_row;
  endtask

  task automatic check_state();
    for (int t = 0; t < 4; t++) begin
      chk("R4 ptr", 192'(phase_ptr[t*4 +: 4]), 192'(m_ptr[t]));
      chk("R7 err", 192'(seq_err[t]), 192'(m_err[t]));
    end
    chk("R9 hbyp", 192'(h_bypass), 192'(m_h));
    chk("R9 vbyp", 192'(v_bypass), 192'(m_v));
  endtask

  task automatic check_rows();
    logic [191:0] r;
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 16; p++)
        if (m_val[t][p]) begin
          rd(t, p, r);
          chk("R3 R10 row", r, m_row[t][p]);
        end
  endtask

  task automatic full_row(int t, logic [31:0] base);
    for (int i = 0; i < nstg(t); i++) wr(6'({t[2:0], 3'(i)}), base + 32'(i));
    wr(6'({t[2:0], 3'd7}), base ^ 32'hA5A5_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [191:0] r, r0;
    int ptr1;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_table = '0; rd_phase = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 R9: reset state
    check_state();

    // R4: sixteen full rows wrap the horizontal luma pointer; R3 readback
    for (int p = 0; p < 16; p++) full_row(0, 32'h1000_0000 + 32'(p * 16));
    chk("R4 wrap", 192'(phase_ptr[3:0]), 192'd0);
    check_state();
    check_rows();

    // R2: staging writes alone leave pointer and rows unchanged
    full_row(1, 32'h2222_0000);
    ptr1 = m_ptr[1];
    rd(1, 0, r0);
    for (int i = 0; i < 5; i++) wr(6'({3'd1, 3'(i)}), 32'hDEAD_0000 + 32'(i));
    chk("R2 ptr", 192'(phase_ptr[7:4]), 192'(ptr1));
    rd(1, 0, r);
    chk("R2 row", r, r0);
    // R8: retrigger reuses staged words
    wr(6'({3'd1, 3'd7}), 32'h0000_BEEF);
    check_rows();
    chk("R8 err", 192'(seq_err[1]), 192'd0);

    // R7: incomplete vertical row sets only that table's flag (R6); R3 zero upper
    wr(6'({3'd2, 3'd0}), 32'h3333_0001);
    wr(6'({3'd2, 3'd7}), 32'h3333_0007);
    chk("R7 set", 192'(seq_err[2]), 192'd1);
    chk("R6 other", 192'(seq_err[3]), 192'd0);
    rd(2, 0, r);
    chk("R3 vrow", r, m_row[2][0]);
    wr(6'({3'd2, 3'd0}), 32'h1);
    wr(6'({3'd2, 3'd1}), 32'h2);
    wr(6'({3'd2, 3'd7}), 32'h3);
    chk("R7 sticky", 192'(seq_err[2]), 192'd1);

    // R5: clear
    wr(6'({3'd2, 3'd6}), 32'h0);
    chk("R5 clr ptr", 192'(phase_ptr[11:8]), 192'd0);
    chk("R5 clr err", 192'(seq_err[2]), 192'd0);

    // R9: bypass bits; R1: unused slots and targets ignored
    wr(6'({3'd4, 3'd0}), 32'h0002_0000);
    check_state();
    wr(6'({3'd4, 3'd3}), 32'hFFFF_FFFF);
    wr(6'({3'd5, 3'd7}), 32'hFFFF_FFFF);
    wr(6'({3'd3, 3'd4}), 32'hFFFF_FFFF);
    chk("R1 ignore", {172'd0, phase_ptr, seq_err}, {172'd0, 4'(m_ptr[3]), 4'(m_ptr[2]),
        4'(m_ptr[1]), 4'(m_ptr[0]), m_err[3], m_err[2], m_err[1], m_err[0]});
    check_state();

    // Random phase, R6 independence checked through full state
    for (int k = 0; k < 1500; k++) begin
      logic [2:0] tg, sl;
      tg = 3'($urandom % 6);
      sl = 3'($urandom % 8);
      if (($urandom % 40) == 0) sl = 3'd6;
      wr({tg, sl}, $urandom);
      if (k % 100 == 99) begin
        check_state();
        check_rows();
      end
    end
    check_state();
    check_rows();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule